// File: doc/BRIEF.md
# Table-Driven I/O Port Dispatcher

This block sits on the I/O side of an 8-bit backplane and turns each port access into strobes for the devices behind it. The 8-bit port number selects one byte from a 256-entry decode table. Each bit of that byte is an active-low select line, so the block inverts the byte before using it. The result drives single-cycle strobes toward four kinds of target:

- a general-purpose port;
- a non-maskable-interrupt port;
- a terminal-logic port;
- two groups of expansion slots, each with its own profile.

Cards that snoop the bus receive the access as well.

The read and write rules follow a fixed order. On a read, the first source that matches supplies the data and the access goes no further. On a write, the general-purpose strobe fires and decoding goes on to the other targets. A write to the interrupt port or the terminal port ends the access at that point. Each slot profile hides the select bits that its connector does not carry. Read data from the slots and the snoopers are merged with a bitwise OR.

The decode table is a parameter. Its default contents are computed when the design is elaborated. Requests are sampled on a clock edge. Every strobe, select, address field and the read-valid flag appears one cycle later and lasts one cycle.

Top module: `io_port_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, every strobe, both slot select buses and `io_rvalid` are low.
- R2: A request counts only when exactly one of `io_rd` and `io_wr` is high. Its strobes appear in the next cycle, for one cycle. A cycle with both high or both low produces no strobe.
- R3: The select vector is the bitwise inverse of table entry `io_port`. Its bits are: bit0 general-purpose, bit1 NMI, bit2 terminal, bit3 cassette, bit4 printer, bit5 floppy, bits 6 and 7 plain peripheral selects. A table byte of 0xFF selects no primary target, so no slot strobe fires.
- R4: On a read, the general-purpose select wins only when `io_port[2:0]` equals 2. `gp_rd` is then the only strobe, and `io_rdata` equals `gp_rdata`.
- R5: On any other read, the NMI select is tested before the terminal select. The winner is the only strobe, `io_rdata` carries its data, and `acc_reg` carries `io_port[2:0]`.
- R6: On a write whose select has bit0 set, `gp_wr` fires in the same cycle as every strobe that the rest of the write decode produces.
- R7: A write whose select has the NMI or the terminal bit set fires `nmi_wr` or `term_wr` (NMI first). It raises neither `slot_wr` nor `snoop_wr`.
- R8: `prof_a_sel` is the select vector with bits 3 and 4 forced to zero.
- R9: `prof_b_sel` is the select vector with bit 5 forced to zero.
- R10: A slot access carries `io_port[2:0]` on `acc_reg`. Its read data is the OR of every byte on `prof_a_rdata` and `prof_b_rdata`.
- R11: Every access not ended early under R4, R5 or R7 raises `snoop_rd` or `snoop_wr`, with the full port on `acc_port`. The OR of all snooper bytes is merged into `io_rdata`.
- R12: `io_rvalid` is high exactly in the cycle after a qualified read. When no strobed source drives a one, `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd | input | 1 | Read request |
| io_wr | input | 1 | Write request |
| io_port | input | 8 | Port number |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Merged read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read result cycle |
| acc_port | output | 8 | Registered full port number |
| acc_reg | output | 3 | Registered register index (port bits 2:0) |
| acc_wdata | output | 8 | Registered write data |
| gp_rd | output | 1 | General-purpose port read strobe |
| gp_wr | output | 1 | General-purpose port write strobe |
| gp_rdata | input | 8 | General-purpose port read data |
| nmi_rd | output | 1 | NMI port read strobe |
| nmi_wr | output | 1 | NMI port write strobe |
| nmi_rdata | input | 8 | NMI port read data |
| term_rd | output | 1 | Terminal port read strobe |
| term_wr | output | 1 | Terminal port write strobe |
| term_rdata | input | 8 | Terminal port read data |
| slot_rd | output | 1 | Slot read strobe |
| slot_wr | output | 1 | Slot write strobe |
| prof_a_sel | output | 8 | Selects for profile-A slots |
| prof_b_sel | output | 8 | Selects for profile-B slots |
| prof_a_rdata | input | 8*NA | Read data of profile-A slots |
| prof_b_rdata | input | 8*NB | Read data of profile-B slots |
| snoop_rd | output | 1 | Snooper read strobe |
| snoop_wr | output | 1 | Snooper write strobe |
| snoop_rdata | input | 8*NS | Read data of snoopers |

## Verification
Two functions can fall in the same cycle.

The first pair is the general-purpose write strobe and a later decode. Writes go to ports whose table byte combines the general-purpose bit with the NMI bit, with the terminal bit, or with nothing else. The bench then requires `gp_wr` next to `nmi_wr`, next to `term_wr`, or next to the slot and snooper strobes, in the same cycle.

The second pair is slot read data and snooper read data. The slot and snooper inputs drive disjoint bit patterns during a slot read, and the bench compares `io_rdata` with their OR. In the same run, reads to the combined general-purpose ports must show that priority stops the merge.

// File: rtl/iodisp_pkg.sv
package iodisp_pkg;

    localparam int SEL_W  = 8;
    localparam int N_PORT = 256;

    localparam int B_GPP  = 0;
    localparam int B_NMI  = 1;
    localparam int B_TERM = 2;
    localparam int B_CASS = 3;
    localparam int B_PRN  = 4;
    localparam int B_FLPY = 5;

    localparam logic [SEL_W-1:0] MASK_A = ~((8'h1 << B_CASS) | (8'h1 << B_PRN));
    localparam logic [SEL_W-1:0] MASK_B = ~(8'h1 << B_FLPY);

    typedef logic [N_PORT-1:0][SEL_W-1:0] rom_t;

    typedef struct packed {
        logic             gp_rd;
        logic             gp_wr;
        logic             nmi_rd;
        logic             nmi_wr;
        logic             term_rd;
        logic             term_wr;
        logic             slot_rd;
        logic             slot_wr;
        logic             snp_rd;
        logic             snp_wr;
        logic             rvalid;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic [7:0]       port;
        logic [2:0]       rsel;
        logic [7:0]       wdata;
    } disp_t;

    // Active-high select per port; the table stores the inverse.
    function automatic logic [SEL_W-1:0] port_sel(input int p);
        logic [SEL_W-1:0] s;
        s = '0;
        if (p >= 8'h78 && p <= 8'h7B) s = 8'h20;
        if (p >= 8'h7C && p <= 8'h7F) s = 8'h78;
        if (p >= 8'hD0 && p <= 8'hD7) s = 8'h40;
        if (p >= 8'hE0 && p <= 8'hE7) s = 8'h90;
        if (p >= 8'hE8 && p <= 8'hEF) s = 8'h04;
        if (p == 8'hF0 || p == 8'hF1 || p == 8'hFB) s = 8'h02;
        if (p == 8'hF2) s = 8'h01;
        if (p == 8'hF3) s = 8'h05;
        if (p == 8'hF8 || p == 8'hF9) s = 8'h08;
        if (p == 8'hFA) s = 8'h03;
        return s;
    endfunction

    function automatic rom_t default_rom();
        rom_t r;
        for (int p = 0; p < N_PORT; p++) r[p] = ~port_sel(p);
        return r;
    endfunction

endpackage

// File: rtl/iodisp_decode.sv
module iodisp_decode
    import iodisp_pkg::*;
#(
    parameter rom_t ROM = default_rom()
) (
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] port,
    input  logic [7:0] wdata,
    output disp_t      nxt
);

    logic [SEL_W-1:0] sel;
    logic             take_rd;
    logic             take_wr;

    always_comb begin
        sel     = ~ROM[port];
        take_rd = rd & ~wr;
        take_wr = wr & ~rd;

        nxt        = '0;
        nxt.port   = port;
        nxt.rsel   = port[2:0];
        nxt.wdata  = wdata;
        nxt.rvalid = take_rd;

        if (take_rd) begin
            if (sel[B_GPP] && port[2:0] == 3'd2) begin
                nxt.gp_rd = 1'b1;
            end else if (sel[B_NMI]) begin
                nxt.nmi_rd = 1'b1;
            end else if (sel[B_TERM]) begin
                nxt.term_rd = 1'b1;
            end else begin
                nxt.slot_rd = |sel;
                nxt.snp_rd  = 1'b1;
                nxt.sel_a   = sel & MASK_A;
                nxt.sel_b   = sel & MASK_B;
            end
        end

        if (take_wr) begin
            nxt.gp_wr = sel[B_GPP];
            if (sel[B_NMI]) begin
                nxt.nmi_wr = 1'b1;
            end else if (sel[B_TERM]) begin
                nxt.term_wr = 1'b1;
            end else begin
                nxt.slot_wr = |sel;
                nxt.snp_wr  = 1'b1;
                nxt.sel_a   = sel & MASK_A;
                nxt.sel_b   = sel & MASK_B;
            end
        end
    end

endmodule

// File: rtl/iodisp_merge.sv
module iodisp_merge #(
    parameter int N = 2
) (
    input  logic [N*8-1:0] data,
    input  logic           en,
    output logic [7:0]     y
);

    logic [7:0] acc [N+1];

    assign acc[0] = 8'h00;

    generate
        for (genvar i = 0; i < N; i++) begin : g_or
            assign acc[i+1] = acc[i] | data[i*8 +: 8];
        end
    endgenerate

    assign y = en ? acc[N] : 8'h00;

endmodule

// File: rtl/io_port_dispatch.sv
module io_port_dispatch
    import iodisp_pkg::*;
#(
    parameter int   NA  = 2,
    parameter int   NB  = 2,
    parameter int   NS  = 2,
    parameter rom_t ROM = default_rom()
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [7:0]      io_port,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    output logic            io_rvalid,
    output logic [7:0]      acc_port,
    output logic [2:0]      acc_reg,
    output logic [7:0]      acc_wdata,
    output logic            gp_rd,
    output logic            gp_wr,
    input  logic [7:0]      gp_rdata,
    output logic            nmi_rd,
    output logic            nmi_wr,
    input  logic [7:0]      nmi_rdata,
    output logic            term_rd,
    output logic            term_wr,
    input  logic [7:0]      term_rdata,
    output logic            slot_rd,
    output logic            slot_wr,
    output logic [7:0]      prof_a_sel,
    output logic [7:0]      prof_b_sel,
    input  logic [NA*8-1:0] prof_a_rdata,
    input  logic [NB*8-1:0] prof_b_rdata,
    output logic            snoop_rd,
    output logic            snoop_wr,
    input  logic [NS*8-1:0] snoop_rdata
);

    disp_t      st_d;
    disp_t      st_q;
    logic [7:0] a_or;
    logic [7:0] b_or;
    logic [7:0] s_or;

    iodisp_decode #(.ROM(ROM)) u_dec (
        .rd    (io_rd),
        .wr    (io_wr),
        .port  (io_port),
        .wdata (io_wdata),
        .nxt   (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    iodisp_merge #(.N(NA)) u_mrg_a (.data(prof_a_rdata), .en(st_q.slot_rd), .y(a_or));
    iodisp_merge #(.N(NB)) u_mrg_b (.data(prof_b_rdata), .en(st_q.slot_rd), .y(b_or));
    iodisp_merge #(.N(NS)) u_mrg_s (.data(snoop_rdata),  .en(st_q.snp_rd),  .y(s_or));

    assign io_rdata = (st_q.gp_rd   ? gp_rdata   : 8'h00)
                    | (st_q.nmi_rd  ? nmi_rdata  : 8'h00)
                    | (st_q.term_rd ? term_rdata : 8'h00)
                    | a_or | b_or | s_or;

    assign io_rvalid  = st_q.rvalid;
    assign acc_port   = st_q.port;
    assign acc_reg    = st_q.rsel;
    assign acc_wdata  = st_q.wdata;
    assign gp_rd      = st_q.gp_rd;
    assign gp_wr      = st_q.gp_wr;
    assign nmi_rd     = st_q.nmi_rd;
    assign nmi_wr     = st_q.nmi_wr;
    assign term_rd    = st_q.term_rd;
    assign term_wr    = st_q.term_wr;
    assign slot_rd    = st_q.slot_rd;
    assign slot_wr    = st_q.slot_wr;
    assign prof_a_sel = st_q.sel_a;
    assign prof_b_sel = st_q.sel_b;
    assign snoop_rd   = st_q.snp_rd;
    assign snoop_wr   = st_q.snp_wr;

    // R2
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_rd | nmi_rd | term_rd | snoop_rd) |-> $past(io_rd & ~io_wr));

    // R2
    wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_wr | nmi_wr | term_wr | snoop_wr) |-> $past(io_wr & ~io_rd));

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gp_rd, nmi_rd, term_rd, snoop_rd}));

    // R7
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_wr | term_wr) |-> !(slot_wr | snoop_wr));

    // R8
    mask_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prof_a_sel[B_CASS] == 1'b0 && prof_a_sel[B_PRN] == 1'b0);

    // R9
    mask_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prof_b_sel[B_FLPY] == 1'b0);

    // R12
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid == $past(io_rd & ~io_wr));

endmodule

// File: tb/io_port_dispatch_tb_top.sv
module io_port_dispatch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_rd, io_wr;
    logic [7:0]  io_port, io_wdata;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [7:0]  acc_port, acc_wdata;
    logic [2:0]  acc_reg;
    logic        gp_rd, gp_wr, nmi_rd, nmi_wr, term_rd, term_wr;
    logic        slot_rd, slot_wr, snoop_rd, snoop_wr;
    logic [7:0]  gp_rdata, nmi_rdata, term_rdata;
    logic [7:0]  prof_a_sel, prof_b_sel;
    logic [15:0] prof_a_rdata, prof_b_rdata, snoop_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    io_port_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .acc_port(acc_port), .acc_reg(acc_reg),
        .acc_wdata(acc_wdata), .gp_rd(gp_rd), .gp_wr(gp_wr),
        .gp_rdata(gp_rdata), .nmi_rd(nmi_rd), .nmi_wr(nmi_wr),
        .nmi_rdata(nmi_rdata), .term_rd(term_rd), .term_wr(term_wr),
        .term_rdata(term_rdata), .slot_rd(slot_rd), .slot_wr(slot_wr),
        .prof_a_sel(prof_a_sel), .prof_b_sel(prof_b_sel),
        .prof_a_rdata(prof_a_rdata), .prof_b_rdata(prof_b_rdata),
        .snoop_rd(snoop_rd), .snoop_wr(snoop_wr), .snoop_rdata(snoop_rdata)
    );

    // Strobe word: gp_rd gp_wr nmi_rd nmi_wr term_rd term_wr slot_rd slot_wr snoop_rd snoop_wr
    function automatic logic [9:0] strobes();
        return {gp_rd, gp_wr, nmi_rd, nmi_wr, term_rd, term_wr,
                slot_rd, slot_wr, snoop_rd, snoop_wr};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one access for a cycle; return at the negedge where its results show.
    task automatic access(input logic rd, input logic wr, input logic [7:0] port);
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_port = port; io_wdata = port ^ 8'h5A;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        io_rd = 1'b1; io_wr = 1'b0; io_port = 8'hF0; io_wdata = 8'h00;
        repeat (2) @(negedge clk);
        check("R1 strobes in reset", {22'd0, strobes()}, 32'h0);
        check("R1 rvalid in reset", {31'd0, io_rvalid}, 32'h0);
        io_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes after reset", {22'd0, strobes()}, 32'h0);
        check("R1 selects after reset", {16'd0, prof_a_sel, prof_b_sel}, 32'h0);
    endtask

    task automatic t_gp_read();
        access(1'b1, 1'b0, 8'hF2);
        check("R4 read F2 strobes", {22'd0, strobes()}, 32'h200);
        check("R4 read F2 data", {24'd0, io_rdata}, 32'h11);
        check("R12 rvalid", {31'd0, io_rvalid}, 32'h1);
        @(negedge clk);
        check("R2 one-cycle strobe", {22'd0, strobes()}, 32'h0);
        check("R12 rvalid drop", {31'd0, io_rvalid}, 32'h0);
        access(1'b1, 1'b0, 8'hFA);
        check("R4 read FA wins over nmi", {22'd0, strobes()}, 32'h200);
        check("R4 read FA data", {24'd0, io_rdata}, 32'h11);
    endtask

    task automatic t_nmi_term_read();
        access(1'b1, 1'b0, 8'hF3);
        check("R4 F3 gp skipped, term", {22'd0, strobes()}, 32'h020);
        check("R5 F3 term data", {24'd0, io_rdata}, 32'h44);
        check("R5 F3 reg", {29'd0, acc_reg}, 32'h3);
        access(1'b1, 1'b0, 8'hF0);
        check("R5 nmi read", {22'd0, strobes()}, 32'h080);
        check("R5 nmi data", {24'd0, io_rdata}, 32'h22);
        access(1'b1, 1'b0, 8'hEA);
        check("R5 term read", {22'd0, strobes()}, 32'h020);
        check("R5 term reg", {29'd0, acc_reg}, 32'h2);
    endtask

    task automatic t_writes();
        access(1'b0, 1'b1, 8'hFA);
        check("R6 R7 write FA", {22'd0, strobes()}, 32'h140);
        access(1'b0, 1'b1, 8'hF3);
        check("R6 R7 write F3", {22'd0, strobes()}, 32'h110);
        access(1'b0, 1'b1, 8'hF2);
        check("R6 R11 write F2", {22'd0, strobes()}, 32'h105);
        check("R11 write F2 wdata", {24'd0, acc_wdata}, 32'hA8);
        access(1'b0, 1'b1, 8'h7D);
        check("R11 write 7D strobes", {22'd0, strobes()}, 32'h005);
        check("R8 profile A select", {24'd0, prof_a_sel}, 32'h60);
        check("R9 profile B select", {24'd0, prof_b_sel}, 32'h58);
        check("R10 slot reg", {29'd0, acc_reg}, 32'h5);
        check("R11 snoop port", {24'd0, acc_port}, 32'h7D);
    endtask

    task automatic t_slot_read();
        access(1'b1, 1'b0, 8'hF8);
        check("R10 read F8 strobes", {22'd0, strobes()}, 32'h00A);
        check("R8 F8 profile A", {24'd0, prof_a_sel}, 32'h00);
        check("R9 F8 profile B", {24'd0, prof_b_sel}, 32'h08);
        check("R10 R11 merged data", {24'd0, io_rdata}, 32'h9B);
    endtask

    task automatic t_empty();
        snoop_rdata = 16'h0000;
        access(1'b1, 1'b0, 8'h00);
        check("R3 empty read strobes", {22'd0, strobes()}, 32'h002);
        check("R12 empty read data", {24'd0, io_rdata}, 32'h00);
        access(1'b0, 1'b1, 8'h00);
        check("R3 empty write strobes", {22'd0, strobes()}, 32'h001);
        snoop_rdata = 16'h1008;
    endtask

    task automatic t_both();
        access(1'b1, 1'b1, 8'hF0);
        check("R2 rd+wr ignored", {22'd0, strobes()}, 32'h0);
        check("R2 rd+wr no rvalid", {31'd0, io_rvalid}, 32'h0);
    endtask

    initial begin
        gp_rdata = 8'h11; nmi_rdata = 8'h22; term_rdata = 8'h44;
        prof_a_rdata = 16'h8001; prof_b_rdata = 16'h0002; snoop_rdata = 16'h1008;
        t_reset();
        t_gp_read();
        t_nmi_term_read();
        t_writes();
        t_slot_read();
        t_empty();
        t_both();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule